// File: doc/BRIEF.md
# Fault-First Vector Byte Load Unit

This unit performs a vector load of one-byte elements from an arbitrary byte address, for an active vector length between 0 and a parameterised maximum (default 64). It breaks the request into naturally aligned 64-bit memory beats and issues them in ascending order. It masks off lanes outside the requested span and places each returned byte at its element position in a wide output register.

Before each beat, the unit presents the page number of that beat to an external translator and samples a page-valid answer. A beat whose page is absent is never issued. If the very first element lies in that beat, the unit reports a genuine fault and leaves the active length alone. Otherwise it stops quietly and returns the elements already loaded. It then writes back a shortened active length equal to their count. A copy loop that began misaligned therefore continues from an aligned boundary on its next pass. The maximum length is a build parameter and is never altered.

Top module: `ffload_top`

## Requirements
- R1: A start with a requested length of 0 produces `done_o` in the cycle after the start edge, with `vl_we_o`=1, `vl_o`=0, `fault_o`=0, and no memory request.
- R2: Beat addresses are 8-byte aligned. The first beat is the doubleword holding the start byte, and each later beat is exactly 8 higher. Bit j of `mem_lanes_o` is 1 exactly when byte address `mem_addr_o`+j lies in [start, start+length).
- R3: `pg_num_o` equals `mem_addr_o` shifted right by log2(PAGE_BYTES). `mem_req_o` is raised only in a cycle where `page_ok_i` is high. After a beat is refused, no further beat of that request is issued.
- R4: When every beat is valid, `done_o` comes with `vl_we_o`=1, `vl_o` equal to the requested length, and `fault_o`=0. Element i appears at `data_o[8i+7:8i]` and equals the byte at start+i. `dmask_o` has bits 0 to length-1 set and all others clear.
- R5: When the first refused beat holds no element 0, `done_o` comes with `fault_o`=0, `vl_we_o`=1, and `vl_o`=n, where n is the number of elements below that beat. `dmask_o` has only its low n bits set, and those elements carry correct data.
- R6: When the beat holding element 0 is refused, `done_o` comes with `fault_o`=1, `vl_we_o`=0 and `dmask_o`=0.
- R7: `done_o` is a single-cycle pulse, and exactly one is produced per accepted request. `fault_o` and `vl_we_o` are only high together with `done_o`.
- R8: `start_i` is ignored while `busy_o` is high. A start arriving mid-request changes neither the beats issued nor the result of the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (taken only when idle) |
| start_addr_i | input | ADDR_W | Byte address of element 0 |
| req_vl_i | input | $clog2(MAX_VL+1) | Requested active length |
| busy_o | output | 1 | A request is in progress |
| mem_req_o | output | 1 | Issue the current beat |
| mem_addr_o | output | ADDR_W | Aligned address of the current beat |
| pg_num_o | output | ADDR_W-log2(PAGE_BYTES) | Page number of the current beat, for translation |
| mem_lanes_o | output | 8 | Byte lanes of the current beat inside the span |
| page_ok_i | input | 1 | Page of the current beat is present |
| mem_rvalid_i | input | 1 | Read data for the issued beat is valid |
| mem_rdata_i | input | 64 | Read data, byte j at bits 8j+7:8j |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| fault_o | output | 1 | Element 0 faulted; no data and no length write |
| vl_we_o | output | 1 | Write `vl_o` as the new active length |
| vl_o | output | $clog2(MAX_VL+1) | Number of elements loaded |
| data_o | output | 8*MAX_VL | Loaded bytes, element i at bits 8i+7:8i |
| dmask_o | output | MAX_VL | Valid-element mask |

## Verification
On every cycle, the assertions check several properties. Requests happen only with a present page and carry a non-empty lane set, and successive beats of one request climb by one doubleword. Done is a lone pulse. A fault brings an empty mask and no length write. Any written length is no larger than the request and matches a contiguous mask prefix, and a zero-length start finishes on the next edge. Only the bench scenarios can show the byte values at each element position and the exact shortened length for every start offset against a missing page. They also show the exact beat count, and that an intruding start during a request leaves it untouched.

// File: rtl/ffload_pkg.sv
package ffload_pkg;

    localparam int LANES  = 8;
    localparam int ELEM_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic              act;
        logic [ELEM_W-1:0] elem;
    } lane_t;

    function automatic int beat_bits(int max_vl);
        return $clog2(max_vl / LANES + 2);
    endfunction

    function automatic int span_bits(int vl_w, int beat_w);
        return ((beat_w + 3 > vl_w) ? beat_w + 3 : vl_w) + 1;
    endfunction

endpackage

// File: rtl/ffload_lane_map.sv
module ffload_lane_map
    import ffload_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int BEAT_W = 4
) (
    input  logic [2:0]        off_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [BEAT_W-1:0] beat_i,
    output lane_t [LANES-1:0] lanes_o
);
    localparam int EW = span_bits(VL_W, BEAT_W);

    logic [EW-1:0] lo, hi;
    assign lo = EW'(off_i);
    assign hi = EW'(off_i) + EW'(vl_i);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [EW-1:0] pos;
        assign pos = EW'({beat_i, 3'b000}) + EW'(j);
        assign lanes_o[j].act  = (pos >= lo) && (pos < hi);
        assign lanes_o[j].elem = ELEM_W'(pos - lo);
    end
endmodule

// File: rtl/ffload_seq.sv
module ffload_seq
    import ffload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VL_W   = 7,
    parameter int BEAT_W = 4,
    parameter int PG_SH  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [VL_W-1:0]     vl_i,
    input  logic                page_ok_i,
    input  logic                rvalid_i,
    output logic                busy_o,
    output logic                accept_o,
    output logic                beat_ok_o,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [ADDR_W-PG_SH-1:0] pg_num_o,
    output logic [2:0]          off_o,
    output logic [VL_W-1:0]     vl_o,
    output logic [BEAT_W-1:0]   beat_o,
    output logic                done_o,
    output logic                fault_o,
    output logic                vl_we_o,
    output logic [VL_W-1:0]     vl_out_o
);
    localparam int EW = span_bits(VL_W, BEAT_W);

    seq_state_e        state_q;
    logic [ADDR_W-4:0] dw_q;
    logic [2:0]        off_q;
    logic [VL_W-1:0]   vl_q;
    logic [BEAT_W-1:0] beat_q;
    logic              done_q, fault_q, we_q;
    logic [VL_W-1:0]   vl_out_q;

    logic [EW-1:0]     span, got;
    logic [BEAT_W-1:0] last_beat;

    assign span      = EW'(off_q) + EW'(vl_q) - EW'(1);
    assign last_beat = BEAT_W'(span >> 3);
    assign got       = EW'({beat_q, 3'b000}) - EW'(off_q);

    assign busy_o     = (state_q != ST_IDLE);
    assign accept_o   = (state_q == ST_IDLE) && start_i;
    assign beat_ok_o  = (state_q == ST_WAIT) && rvalid_i;
    assign mem_req_o  = (state_q == ST_ISSUE) && page_ok_i;
    assign mem_addr_o = {dw_q + (ADDR_W-3)'(beat_q), 3'b000};
    assign pg_num_o   = mem_addr_o[ADDR_W-1:PG_SH];
    assign off_o      = off_q;
    assign vl_o       = vl_q;
    assign beat_o     = beat_q;
    assign done_o     = done_q;
    assign fault_o    = fault_q;
    assign vl_we_o    = we_q;
    assign vl_out_o   = vl_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            dw_q     <= '0;
            off_q    <= '0;
            vl_q     <= '0;
            beat_q   <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            we_q     <= 1'b0;
            vl_out_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            we_q    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dw_q   <= addr_i[ADDR_W-1:3];
                        off_q  <= addr_i[2:0];
                        vl_q   <= vl_i;
                        beat_q <= '0;
                        if (vl_i == '0) begin
                            done_q   <= 1'b1;
                            we_q     <= 1'b1;
                            vl_out_q <= '0;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (page_ok_i) begin
                        state_q <= ST_WAIT;
                    end else begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        if (beat_q == '0) begin
                            fault_q <= 1'b1;
                        end else begin
                            we_q     <= 1'b1;
                            vl_out_q <= VL_W'(got);
                        end
                    end
                end
                ST_WAIT: begin
                    if (rvalid_i) begin
                        if (beat_q == last_beat) begin
                            state_q  <= ST_IDLE;
                            done_q   <= 1'b1;
                            we_q     <= 1'b1;
                            vl_out_q <= vl_q;
                        end else begin
                            beat_q  <= beat_q + BEAT_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ffload_collect.sv
module ffload_collect
    import ffload_pkg::*;
#(
    parameter int MAX_VL = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear_i,
    input  logic                  wr_i,
    input  lane_t [LANES-1:0]     lanes_i,
    input  logic [8*LANES-1:0]    rdata_i,
    output logic [8*MAX_VL-1:0]   data_o,
    output logic [MAX_VL-1:0]     mask_o
);
    localparam int IX_W = $clog2(MAX_VL);

    logic [LANES-1:0][IX_W-1:0] ix;
    for (genvar j = 0; j < LANES; j++) begin : g_ix
        assign ix[j] = lanes_i[j].elem[IX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            data_o <= '0;
            mask_o <= '0;
        end else if (wr_i) begin
            for (int j = 0; j < LANES; j++) begin
                if (lanes_i[j].act) begin
                    data_o[8*ix[j] +: 8] <= rdata_i[8*j +: 8];
                    mask_o[ix[j]]        <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ffload_top.sv
module ffload_top
    import ffload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_VL     = 64,
    parameter int PAGE_BYTES = 4096,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int PG_SH     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       start_addr_i,
    input  logic [VL_W-1:0]         req_vl_i,
    output logic                    busy_o,
    output logic                    mem_req_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic [ADDR_W-PG_SH-1:0] pg_num_o,
    output logic [7:0]              mem_lanes_o,
    input  logic                    page_ok_i,
    input  logic                    mem_rvalid_i,
    input  logic [63:0]             mem_rdata_i,
    output logic                    done_o,
    output logic                    fault_o,
    output logic                    vl_we_o,
    output logic [VL_W-1:0]         vl_o,
    output logic [8*MAX_VL-1:0]     data_o,
    output logic [MAX_VL-1:0]       dmask_o
);
    localparam int BEAT_W = beat_bits(MAX_VL);

    logic              accept, beat_ok;
    logic [2:0]        off;
    logic [VL_W-1:0]   cur_vl;
    logic [BEAT_W-1:0] beat;
    lane_t [LANES-1:0] lanes;

    ffload_seq #(
        .ADDR_W(ADDR_W), .VL_W(VL_W), .BEAT_W(BEAT_W), .PG_SH(PG_SH)
    ) i_seq (
        .clk(clk), .rst(rst),
        .start_i(start_i), .addr_i(start_addr_i), .vl_i(req_vl_i),
        .page_ok_i(page_ok_i), .rvalid_i(mem_rvalid_i),
        .busy_o(busy_o), .accept_o(accept), .beat_ok_o(beat_ok),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .pg_num_o(pg_num_o),
        .off_o(off), .vl_o(cur_vl), .beat_o(beat),
        .done_o(done_o), .fault_o(fault_o), .vl_we_o(vl_we_o), .vl_out_o(vl_o)
    );

    ffload_lane_map #(
        .VL_W(VL_W), .BEAT_W(BEAT_W)
    ) i_lanes (
        .off_i(off), .vl_i(cur_vl), .beat_i(beat), .lanes_o(lanes)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_en
        assign mem_lanes_o[j] = lanes[j].act;
    end

    ffload_collect #(
        .MAX_VL(MAX_VL)
    ) i_collect (
        .clk(clk), .rst(rst),
        .clear_i(accept), .wr_i(beat_ok),
        .lanes_i(lanes), .rdata_i(mem_rdata_i),
        .data_o(data_o), .mask_o(dmask_o)
    );
endmodule

// File: rtl/ffload_chk.sv
module ffload_chk #(
    parameter int ADDR_W = 32,
    parameter int MAX_VL = 64,
    parameter int PG_W   = 20,
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [VL_W-1:0]   req_vl_i,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        mem_lanes_o,
    input logic              page_ok_i,
    input logic              done_o,
    input logic              fault_o,
    input logic              vl_we_o,
    input logic [VL_W-1:0]   vl_o,
    input logic [MAX_VL-1:0] dmask_o
);
    logic [VL_W-1:0]   req_q;
    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;
    logic [MAX_VL-1:0] prefix;

    assign prefix = ~({MAX_VL{1'b1}} << vl_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            prev_addr <= '0;
            have_prev <= 1'b0;
        end else if (start_i && !busy_o) begin
            req_q     <= req_vl_i;
            have_prev <= 1'b0;
        end else if (mem_req_o) begin
            prev_addr <= mem_addr_o;
            have_prev <= 1'b1;
        end
    end

    a_r3_req_needs_page: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> page_ok_i);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o);

    a_r2_lanes_live: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> mem_lanes_o != 8'h00);

    a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && have_prev) |-> mem_addr_o == prev_addr + ADDR_W'(8));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_flags_with_done: assert property (@(posedge clk) disable iff (rst)
        (fault_o || vl_we_o) |-> done_o);

    a_r6_fault_empty: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!vl_we_o && dmask_o == '0));

    a_r5_vl_bounded: assert property (@(posedge clk) disable iff (rst)
        vl_we_o |-> vl_o <= req_q);

    a_r4_mask_prefix: assert property (@(posedge clk) disable iff (rst)
        vl_we_o |-> dmask_o == prefix);

    a_r1_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && req_vl_i == '0) |=> (done_o && vl_we_o && vl_o == '0));
endmodule

bind ffload_top ffload_chk #(
    .ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .PG_W(ADDR_W - PG_SH)
) i_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .req_vl_i(req_vl_i),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_lanes_o(mem_lanes_o), .page_ok_i(page_ok_i), .done_o(done_o),
    .fault_o(fault_o), .vl_we_o(vl_we_o), .vl_o(vl_o), .dmask_o(dmask_o)
);

// File: tb/test_ffload_top.sv
module test_ffload_top;
    localparam int ADDR_W = 32;
    localparam int MAX_VL = 64;
    localparam int PAGE   = 4096;
    localparam int VL_W   = $clog2(MAX_VL + 1);
    localparam int PG_W   = ADDR_W - $clog2(PAGE);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic [VL_W-1:0] req_vl_i = '0;
    logic busy_o, mem_req_o, page_ok_i, done_o, fault_o, vl_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [PG_W-1:0] pg_num_o;
    logic [7:0] mem_lanes_o;
    logic mem_rvalid_i = 1'b0;
    logic [63:0] mem_rdata_i = '0;
    logic [VL_W-1:0] vl_o;
    logic [8*MAX_VL-1:0] data_o;
    logic [MAX_VL-1:0] dmask_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int run_a = 0, run_v = 0, run_reqs = 0, run_dones = 0;
    bit bad_en = 1'b0;
    int bad_pg = 0;
    bit nxt_valid = 1'b0;
    logic [63:0] nxt_data = '0;

    always #5 clk = ~clk;

    assign page_ok_i = !(bad_en && (int'(pg_num_o) == bad_pg));

    ffload_top #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .PAGE_BYTES(PAGE)) i_ffload_top (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .req_vl_i(req_vl_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .pg_num_o(pg_num_o), .mem_lanes_o(mem_lanes_o),
        .page_ok_i(page_ok_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .fault_o(fault_o), .vl_we_o(vl_we_o), .vl_o(vl_o),
        .data_o(data_o), .dmask_o(dmask_o)
    );

    function automatic logic [7:0] mbyte(int x);
        return x[7:0] ^ x[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // memory and translation responder: observe at negedge, answer at next posedge
    always @(negedge clk) begin
        if (!rst && mem_req_o) begin
            int b;
            logic [7:0] el;
            b = (run_a & ~7) + 8 * run_reqs;
            chk(int'(mem_addr_o) == b, "R2", "beat address", mem_addr_o, b);
            for (int j = 0; j < 8; j++)
                el[j] = ((b + j) >= run_a) && ((b + j) < run_a + run_v);
            chk(mem_lanes_o == el, "R2", "lane enables", mem_lanes_o, el);
            chk(int'(pg_num_o) == (b >> 12), "R3", "page number", pg_num_o, b >> 12);
            for (int j = 0; j < 8; j++)
                nxt_data[8*j +: 8] = mbyte(int'(mem_addr_o) + j);
            nxt_valid = 1'b1;
            run_reqs++;
        end else begin
            nxt_valid = 1'b0;
        end
        if (!rst && done_o) run_dones++;
    end

    always @(posedge clk) begin
        mem_rvalid_i <= nxt_valid;
        mem_rdata_i  <= nxt_data;
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(int a, int v, int mode, bit intrude);
        int n, exp_reqs, waited, errs;
        bit exp_fault, exp_we, got_done;
        int pga;
        pga = a >> 12;
        bad_en = (mode != 0);
        bad_pg = (mode == 1) ? pga + 1 : pga;
        if (v == 0) begin
            n = 0; exp_fault = 0; exp_we = 1;
        end else if (mode == 2) begin
            n = 0; exp_fault = 1; exp_we = 0;
        end else if (mode == 1 && ((pga + 1) * PAGE - a) < v) begin
            n = (pga + 1) * PAGE - a; exp_fault = 0; exp_we = 1;
        end else begin
            n = v; exp_fault = 0; exp_we = 1;
        end
        exp_reqs = (v == 0 || exp_fault) ? 0 : ((a & 7) + n + 7) / 8;

        @(negedge clk);
        run_a = a; run_v = v; run_reqs = 0; run_dones = 0;
        start_i = 1'b1;
        start_addr_i = ADDR_W'(a);
        req_vl_i = VL_W'(v);
        @(negedge clk);
        start_i = 1'b0;
        waited = 1;
        got_done = 1'b0;
        while (!got_done && waited < 200) begin
            if (done_o) begin
                got_done = 1'b1;
            end else begin
                // R8: a second start while busy must be ignored
                start_i = intrude && busy_o && waited == 1;
                start_addr_i = ADDR_W'(a + 333);
                req_vl_i = VL_W'(3);
                @(negedge clk);
                start_i = 1'b0;
                waited++;
            end
        end
        chk(got_done, "R7", "done seen", got_done, 1);
        if (v == 0) chk(waited == 1, "R1", "zero-length latency", waited, 1);
        chk(fault_o == exp_fault, exp_fault ? "R6" : "R5", "fault flag", fault_o, exp_fault);
        chk(vl_we_o == exp_we, exp_fault ? "R6" : "R4", "vl write enable", vl_we_o, exp_we);
        if (exp_we)
            chk(int'(vl_o) == n, (n < v) ? "R5" : "R4", "new vl", vl_o, n);
        chk(dmask_o == ~({MAX_VL{1'b1}} << n), (n < v) ? "R5" : "R4", "mask popcount",
            $countones(dmask_o), n);
        errs = 0;
        for (int i = 0; i < n; i++)
            if (data_o[8*i +: 8] != mbyte(a + i)) errs++;
        chk(errs == 0, (n < v) ? "R5" : "R4", "element bytes wrong", errs, 0);
        chk(run_reqs == exp_reqs, (v == 0) ? "R1" : "R3", "beats issued", run_reqs, exp_reqs);
        @(negedge clk);
        chk(run_dones == 1, intrude ? "R8" : "R7", "done pulses", run_dones, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_o, "R7", "reset outputs quiet",
            {busy_o, done_o, mem_req_o}, 0);
        chk(dmask_o == '0, "R4", "reset mask", $countones(dmask_o), 0);
        rst = 1'b0;
        for (int mode = 0; mode < 3; mode++)
            for (int d = 1; d <= 24; d++)
                for (int v = 0; v <= MAX_VL; v++)
                    run(2 * PAGE - d, v, mode, (v % 5) == 2);
        // aligned starts well inside a page
        for (int v = 0; v <= MAX_VL; v += 8)
            run(PAGE + 512, v, 0, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule